// File: doc/BRIEF.md
# Bit-Addressable Memory Access Unit

This unit carries out single-bit operations on a byte-wide, 256-location on-chip data and register space. An 8-bit bit address is split into a byte address and a bit position. Bit addresses in the lower half reach a 16-byte general-purpose RAM window starting at byte 20H. Bit addresses in the upper half reach the register bytes whose addresses are multiples of eight, such as the I/O ports, timer and serial control, interrupt enable and priority, status word, accumulator and B register.

Every operation is a byte read followed, when the operation needs it, by a byte write-back in which only the selected bit can differ from the byte that was read. The operation set covers four bit writes (clear, set, complement, copy carry into bit), a load of the bit into carry, four carry-logic combinations (AND or OR with the bit or its inverse) that leave the memory untouched, and an atomic test-and-clear for a jump-on-bit-set-then-clear instruction. A caller pulses `start_i` while the unit is idle, watches `busy_o`, and takes the carry and bit results when `done_o` pulses. Branch target computation is left to the caller.

Top module: `bitop_unit`

## Requirements
- R1: A bit address 00H-7FH selects byte 20H + (address / 8) at bit position (address mod 8). Example: bit 3EH is bit 6 of byte 27H.
- R2: A bit address 80H-FFH selects the byte whose address is the bit address with its low three bits cleared, at bit position (address mod 8). Example: bit 0BEH is bit 6 of byte 0B8H.
- R3: Op codes 0 (clear), 1 (set), 2 (complement) and 3 (copy carry_i into the bit) write the byte back with the selected bit forced to 0, forced to 1, inverted, or equal to carry_i.
- R4: Any write-back leaves the seven unselected bits of the byte equal to the values that were read.
- R5: Op code 4 drives carry_o to the selected bit, and no write is issued.
- R6: Op codes 5 (carry AND bit), 6 (carry AND NOT bit), 7 (carry OR bit) and 8 (carry OR NOT bit) drive carry_o to that function of carry_i and the bit, and no write is issued.
- R7: Op code 9 (test-and-clear) drives bit_o to the bit value that was read; when it was 1 the byte is written back with that bit 0, and when it was 0 no write is issued.
- R8: An accepted operation asserts mem_rd_o in the cycle after acceptance, issues any write (mem_wr_o) two cycles after the read, to the same byte address, and pulses done_o for exactly one cycle: 3 cycles after acceptance with no write, 4 with a write. mem_rdata_i must be valid the cycle after mem_rd_o.
- R9: start_i is ignored while busy_o is high; busy_o is high from the cycle after acceptance through the done_o cycle.
- R10: After reset, busy_o, done_o, carry_o, bit_o, mem_rd_o and mem_wr_o are all 0.
- R11: Op codes 10-15 read the byte, issue no write, and pass carry_i through to carry_o.
- R12: carry_o and bit_o are registered and hold their values after done_o until the next operation completes; for op codes 0-3 and 9, carry_o equals carry_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation (taken only while idle) |
| op_i | input | 4 | Operation code (see R3, R5-R7, R11) |
| bit_addr_i | input | 8 | Bit address |
| carry_i | input | 1 | Carry flag in |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Carry flag result |
| bit_o | output | 1 | Selected bit as read |
| mem_addr_o | output | 8 | Memory byte address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data (one-cycle latency) |

## Verification
Assertions check the following on every cycle:
- the address split for both halves of the bit space, seen at the first read cycle;
- that a write comes exactly two cycles after its read and targets the same byte;
- that no more than one bit of a written byte differs from the byte that was read;
- the one-cycle done pulse, and that the latched request stays frozen while busy;
- that the carry-only operations never write;
- that test-and-clear writes exactly when the bit read as 1.

Only the bench scenarios show three further properties:
- the actual values stored for each write operation;
- the carry results of the logic operations;
- that a second request raised while busy leaves no trace in memory.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_CLR   = 4'd0;
  localparam logic [OP_W-1:0] OP_SET   = 4'd1;
  localparam logic [OP_W-1:0] OP_CPL   = 4'd2;
  localparam logic [OP_W-1:0] OP_STC   = 4'd3;
  localparam logic [OP_W-1:0] OP_LDC   = 4'd4;
  localparam logic [OP_W-1:0] OP_ANDC  = 4'd5;
  localparam logic [OP_W-1:0] OP_ANDNC = 4'd6;
  localparam logic [OP_W-1:0] OP_ORC   = 4'd7;
  localparam logic [OP_W-1:0] OP_ORNC  = 4'd8;
  localparam logic [OP_W-1:0] OP_TCLR  = 4'd9;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_EVAL,
    S_WR,
    S_FIN
  } state_t;
endpackage

// File: rtl/bitop_addr_map.sv
module bitop_addr_map #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int WIN_BASE = 'h20,
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic [ADDR_W-1:0] bit_addr_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic in_win;
  logic [ADDR_W-1:0] win_addr;
  logic [ADDR_W-1:0] reg_addr;

  assign in_win   = ~bit_addr_i[ADDR_W-1];
  assign win_addr = ADDR_W'(WIN_BASE) + ADDR_W'(bit_addr_i[ADDR_W-2:IDX_W]);
  assign reg_addr = {bit_addr_i[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};

  assign byte_addr_o = in_win ? win_addr : reg_addr;
  assign idx_o       = bit_addr_i[IDX_W-1:0];
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rbyte_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] wbyte_o,
  output logic              wr_o,
  output logic              cout_o,
  output logic              bit_o
);
  logic [DATA_W-1:0] mask;
  logic              nbit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (idx_i == IDX_W'(i));
  end

  assign bit_o = |(rbyte_i & mask);

  always_comb begin
    nbit   = bit_o;
    wr_o   = 1'b0;
    cout_o = cin_i;
    unique case (op_i)
      OP_CLR:   begin nbit = 1'b0;   wr_o = 1'b1; end
      OP_SET:   begin nbit = 1'b1;   wr_o = 1'b1; end
      OP_CPL:   begin nbit = ~bit_o; wr_o = 1'b1; end
      OP_STC:   begin nbit = cin_i;  wr_o = 1'b1; end
      OP_LDC:   cout_o = bit_o;
      OP_ANDC:  cout_o = cin_i & bit_o;
      OP_ANDNC: cout_o = cin_i & ~bit_o;
      OP_ORC:   cout_o = cin_i | bit_o;
      OP_ORNC:  cout_o = cin_i | ~bit_o;
      OP_TCLR:  begin nbit = 1'b0;   wr_o = bit_o; end
      default:  ;
    endcase
  end

  assign wbyte_o = (rbyte_i & ~mask) | (nbit ? mask : '0);
endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] alu_wbyte_i,
  input  logic              alu_wr_i,
  input  logic              alu_cout_i,
  input  logic              alu_bit_i,
  output logic [OP_W-1:0]   op_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              cin_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              carry_o,
  output logic              bit_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  state_t            state_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              cin_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] wdata_q;
  logic              carry_q;
  logic              bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      idx_q   <= '0;
      cin_q   <= 1'b0;
      rd_q    <= '0;
      wdata_q <= '0;
      carry_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          op_q    <= op_i;
          addr_q  <= byte_addr_i;
          idx_q   <= idx_i;
          cin_q   <= carry_i;
          state_q <= S_RD;
        end
        S_RD: state_q <= S_EVAL;
        S_EVAL: begin
          rd_q    <= mem_rdata_i;
          wdata_q <= alu_wbyte_i;
          carry_q <= alu_cout_i;
          bit_q   <= alu_bit_i;
          state_q <= alu_wr_i ? S_WR : S_FIN;
        end
        S_WR:    state_q <= S_FIN;
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign op_o        = op_q;
  assign idx_o       = idx_q;
  assign cin_o       = cin_q;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign carry_o     = carry_q;
  assign bit_o       = bit_q;
  assign mem_addr_o  = addr_q;
  assign mem_rd_o    = (state_q == S_RD);
  assign mem_wr_o    = (state_q == S_WR);
  assign mem_wdata_o = wdata_q;

  // R8: done_o lasts exactly one cycle
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8: a write comes two cycles after the read, to the same byte
  p_wr_after_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(mem_rd_o, 2) && mem_addr_o == $past(mem_addr_o, 2)));

  // R4: at most the selected bit differs from the byte read
  p_one_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($countones(mem_wdata_o ^ rd_q) <= 1));

  // R9: the latched request is frozen while busy
  p_hold_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(op_q) && $stable(addr_q) && $stable(idx_q) && $stable(cin_q)));

  // R6: the carry-only ops never write
  p_carry_nowr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EVAL && op_q >= OP_LDC && op_q <= OP_ORNC) |=> !mem_wr_o);

  // R7: test-and-clear writes exactly when the bit read as 1
  p_tclr_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EVAL && op_q == OP_TCLR) |=> (mem_wr_o == $past(mem_rdata_i[idx_q])));
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int WIN_BASE = 'h20,
  localparam int IDX_W   = $clog2(DATA_W),
  localparam int WIN_LEN = 1 << (ADDR_W - 1 - IDX_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  input  logic              carry_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              carry_o,
  output logic              bit_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [ADDR_W-1:0] map_addr;
  logic [IDX_W-1:0]  map_idx;
  logic [OP_W-1:0]   cur_op;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_cin;
  logic [DATA_W-1:0] alu_wbyte;
  logic              alu_wr;
  logic              alu_cout;
  logic              alu_bit;

  bitop_addr_map #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WIN_BASE(WIN_BASE)
  ) u_map (
    .bit_addr_i (bit_addr_i),
    .byte_addr_o(map_addr),
    .idx_o      (map_idx)
  );

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .rbyte_i(mem_rdata_i),
    .idx_i  (cur_idx),
    .op_i   (cur_op),
    .cin_i  (cur_cin),
    .wbyte_o(alu_wbyte),
    .wr_o   (alu_wr),
    .cout_o (alu_cout),
    .bit_o  (alu_bit)
  );

  bitop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_i       (op_i),
    .byte_addr_i(map_addr),
    .idx_i      (map_idx),
    .carry_i    (carry_i),
    .mem_rdata_i(mem_rdata_i),
    .alu_wbyte_i(alu_wbyte),
    .alu_wr_i   (alu_wr),
    .alu_cout_i (alu_cout),
    .alu_bit_i  (alu_bit),
    .op_o       (cur_op),
    .idx_o      (cur_idx),
    .cin_o      (cur_cin),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .carry_o    (carry_o),
    .bit_o      (bit_o),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  // R1: low half lands in the RAM window at the first read
  p_low_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !bit_addr_i[ADDR_W-1]) |=>
      (mem_rd_o && mem_addr_o >= ADDR_W'(WIN_BASE) &&
       mem_addr_o <= ADDR_W'(WIN_BASE + WIN_LEN - 1)));

  // R2: high half lands on an aligned register byte
  p_high_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && bit_addr_i[ADDR_W-1]) |=>
      (mem_rd_o && mem_addr_o[IDX_W-1:0] == '0 &&
       mem_addr_o[ADDR_W-1:IDX_W] == $past(bit_addr_i[ADDR_W-1:IDX_W])));
endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op_s = '0;
  logic [7:0] addr_s = '0;
  logic       cin = 1'b0;
  logic       busy_o, done_o, carry_o, bit_o, mem_rd_o, mem_wr_o;
  logic [7:0] mem_addr_o, mem_wdata_o;
  logic [7:0] mem_rdata = '0;
  logic [7:0] mem [256];
  int         n_checks = 0;
  int         n_fail = 0;
  int         wr_cnt = 0;
  int         cycles = 0;

  always #4 clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op_s),
    .bit_addr_i(addr_s), .carry_i(cin), .busy_o(busy_o), .done_o(done_o),
    .carry_o(carry_o), .bit_o(bit_o), .mem_addr_o(mem_addr_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata <= mem[mem_addr_o];
    if (mem_wr_o) begin
      mem[mem_addr_o] <= mem_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic c,
                        output int cyc);
    @(negedge clk);
    start = 1'b1; op_s = op; addr_s = a; cin = c;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 16) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic chk_pulse_end();
    @(negedge clk);
    chk("R8 done pulse ends", int'(done_o), 0);
    chk("R9 idle after done", int'(busy_o), 0);
  endtask

  task automatic t_reset();
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 done", int'(done_o), 0);
    chk("R10 carry", int'(carry_o), 0);
    chk("R10 bit", int'(bit_o), 0);
    chk("R10 rd/wr", int'({mem_rd_o, mem_wr_o}), 0);
  endtask

  task automatic t_low_map();
    int cyc;
    mem[8'h27] = 8'hA5; mem[8'h26] = 8'h5A; mem[8'h28] = 8'h5A;
    mem[8'h20] = 8'h00; mem[8'h2F] = 8'h00;
    run_op(4'd1, 8'h3E, 1'b0, cyc);
    chk("R8 write op latency", cyc, 4);
    chk("R12 carry pass on set", int'(carry_o), 0);
    chk_pulse_end();
    chk("R1 3E -> 27h.6", int'(mem[8'h27]), 'hE5);
    chk("R4 neighbour 26h", int'(mem[8'h26]), 'h5A);
    chk("R4 neighbour 28h", int'(mem[8'h28]), 'h5A);
    run_op(4'd1, 8'h00, 1'b1, cyc);
    chk("R12 carry pass on set", int'(carry_o), 1);
    chk_pulse_end();
    chk("R1 00 -> 20h.0", int'(mem[8'h20]), 'h01);
    run_op(4'd1, 8'h7F, 1'b0, cyc);
    chk_pulse_end();
    chk("R1 7F -> 2Fh.7", int'(mem[8'h2F]), 'h80);
  endtask

  task automatic t_high_map();
    int cyc;
    mem[8'hB8] = 8'h00; mem[8'hBE] = 8'h00; mem[8'h80] = 8'hFF;
    mem[8'hF8] = 8'h00; mem[8'hFF] = 8'h00;
    run_op(4'd1, 8'hBE, 1'b0, cyc);
    chk_pulse_end();
    chk("R2 BE -> B8h.6", int'(mem[8'hB8]), 'h40);
    chk("R2 byte BEh untouched", int'(mem[8'hBE]), 'h00);
    run_op(4'd0, 8'h87, 1'b0, cyc);
    chk_pulse_end();
    chk("R2 87 -> 80h.7 clear", int'(mem[8'h80]), 'h7F);
    run_op(4'd1, 8'hFF, 1'b0, cyc);
    chk_pulse_end();
    chk("R2 FF -> F8h.7", int'(mem[8'hF8]), 'h80);
    chk("R2 byte FFh untouched", int'(mem[8'hFF]), 'h00);
  endtask

  task automatic t_writes();
    int cyc;
    mem[8'h22] = 8'h0F;
    run_op(4'd2, 8'h11, 1'b0, cyc);
    chk_pulse_end();
    chk("R3 complement 1->0", int'(mem[8'h22]), 'h0D);
    run_op(4'd2, 8'h17, 1'b0, cyc);
    chk_pulse_end();
    chk("R3 complement 0->1", int'(mem[8'h22]), 'h8D);
    run_op(4'd3, 8'h12, 1'b1, cyc);
    chk_pulse_end();
    chk("R3 copy carry 1", int'(mem[8'h22]), 'h8D);
    run_op(4'd3, 8'h13, 1'b0, cyc);
    chk_pulse_end();
    chk("R3 copy carry 0", int'(mem[8'h22]), 'h85);
    run_op(4'd0, 8'h10, 1'b0, cyc);
    chk_pulse_end();
    chk("R3 clear", int'(mem[8'h22]), 'h84);
  endtask

  task automatic t_load();
    int cyc, w0;
    mem[8'h24] = 8'h10;
    w0 = wr_cnt;
    run_op(4'd4, 8'h24, 1'b0, cyc);
    chk("R8 no-write latency", cyc, 3);
    chk("R5 carry <- bit 1", int'(carry_o), 1);
    chk("R5 bit_o", int'(bit_o), 1);
    chk_pulse_end();
    chk("R12 carry held", int'(carry_o), 1);
    run_op(4'd4, 8'h25, 1'b1, cyc);
    chk("R5 carry <- bit 0", int'(carry_o), 0);
    chk_pulse_end();
    chk("R5 no write", wr_cnt - w0, 0);
    chk("R5 byte kept", int'(mem[8'h24]), 'h10);
  endtask

  task automatic t_logic();
    int cyc, w0;
    mem[8'h25] = 8'h01;
    w0 = wr_cnt;
    run_op(4'd5, 8'h28, 1'b1, cyc); chk("R6 1&1", int'(carry_o), 1); chk_pulse_end();
    run_op(4'd5, 8'h29, 1'b1, cyc); chk("R6 1&0", int'(carry_o), 0); chk_pulse_end();
    run_op(4'd5, 8'h28, 1'b0, cyc); chk("R6 0&1", int'(carry_o), 0); chk_pulse_end();
    run_op(4'd6, 8'h29, 1'b1, cyc); chk("R6 1&~0", int'(carry_o), 1); chk_pulse_end();
    run_op(4'd6, 8'h28, 1'b1, cyc); chk("R6 1&~1", int'(carry_o), 0); chk_pulse_end();
    run_op(4'd7, 8'h29, 1'b0, cyc); chk("R6 0|0", int'(carry_o), 0); chk_pulse_end();
    run_op(4'd7, 8'h28, 1'b0, cyc); chk("R6 0|1", int'(carry_o), 1); chk_pulse_end();
    run_op(4'd8, 8'h28, 1'b0, cyc); chk("R6 0|~1", int'(carry_o), 0); chk_pulse_end();
    run_op(4'd8, 8'h29, 1'b0, cyc);
    chk("R6 0|~0", int'(carry_o), 1);
    chk("R6 latency", cyc, 3);
    chk_pulse_end();
    chk("R6 no write", wr_cnt - w0, 0);
    chk("R6 byte kept", int'(mem[8'h25]), 'h01);
  endtask

  task automatic t_tclr();
    int cyc, w0;
    mem[8'hD0] = 8'h81;
    w0 = wr_cnt;
    run_op(4'd9, 8'hD7, 1'b1, cyc);
    chk("R7 bit was 1", int'(bit_o), 1);
    chk("R7 write latency", cyc, 4);
    chk("R12 carry pass on test", int'(carry_o), 1);
    chk_pulse_end();
    chk("R7 cleared", int'(mem[8'hD0]), 'h01);
    chk("R7 one write", wr_cnt - w0, 1);
    run_op(4'd9, 8'hD7, 1'b0, cyc);
    chk("R7 bit was 0", int'(bit_o), 0);
    chk("R7 no-write latency", cyc, 3);
    chk_pulse_end();
    chk("R7 no write when 0", wr_cnt - w0, 1);
    chk("R7 byte kept", int'(mem[8'hD0]), 'h01);
  endtask

  task automatic t_undef();
    int cyc, w0;
    mem[8'h20] = 8'h01;
    w0 = wr_cnt;
    run_op(4'hC, 8'h00, 1'b1, cyc);
    chk("R11 carry passes 1", int'(carry_o), 1);
    chk_pulse_end();
    run_op(4'hF, 8'h00, 1'b0, cyc);
    chk("R11 carry passes 0", int'(carry_o), 0);
    chk("R11 latency", cyc, 3);
    chk_pulse_end();
    chk("R11 no write", wr_cnt - w0, 0);
    chk("R11 byte kept", int'(mem[8'h20]), 'h01);
  endtask

  task automatic t_busy();
    int cyc;
    mem[8'h21] = 8'h00; mem[8'h2A] = 8'h00;
    @(negedge clk);
    start = 1'b1; op_s = 4'd1; addr_s = 8'h08; cin = 1'b0;
    @(negedge clk);
    op_s = 4'd1; addr_s = 8'h50;
    chk("R9 busy after accept", int'(busy_o), 1);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 3;
    while (!done_o && cyc < 16) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 first op timing", cyc, 4);
    chk_pulse_end();
    chk("R9 no new read", int'(mem_rd_o), 0);
    chk("R9 first op applied", int'(mem[8'h21]), 'h01);
    chk("R9 second op ignored", int'(mem[8'h2A]), 'h00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_map();
    t_high_map();
    t_writes();
    t_load();
    t_logic();
    t_tclr();
    t_undef();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule